// File: doc/BRIEF.md
# PMP configuration register bank

This block holds the physical memory protection state of a hart: one 8-bit permission byte and one address register per protection entry, with 1 to 64 entries. Machine-mode software reaches the state through a simple register port. A select bit chooses between the packed permission registers and the address registers, and an index picks the register. Writes are taken on the clock edge. Reads are combinational. Every entry's permission byte and its address value, as software reads it, are also driven out in parallel to the access checkers that sit downstream.

Permission bytes are packed several to a register: four per register with a 32-bit data width, eight per register with a 64-bit width. In the 64-bit layout only even register indices exist. Setting an entry's lock bit freezes that entry. A coarse protection grain of 2^(GRAN+2) bytes is applied when an address is read back, and the stored bits are kept.

Top module: `pmp_cfg_bank`

## Requirements
- R1: After a synchronous active-low reset every permission byte is 0 (off, unlocked) and every address register is 0, and all of them read back as 0.
- R2: Permission byte fields: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (00 off, 01 top-of-range, 10 four-byte naturally aligned, 11 power-of-two naturally aligned), bit 7 lock. Bits 6:5 always read as 0.
- R3: Packing. With XLEN=32, entry e sits in permission register e>>2 at bits (e%4)*8+7:(e%4)*8. With XLEN=64, entry e sits in register (e>>3)*2 at bits (e%8)*8+7:(e%8)*8, and odd register indices read 0 and ignore writes.
- R4: A permission register index that holds no implemented entry, or an address index at or above N_ENTRIES, reads 0 and ignores writes. Bytes of a partly used permission register that belong to missing entries read 0.
- R5: A write to a permission register updates each byte on its own. A byte whose lock bit is set keeps its value, and unlocked bytes in the same register take the new data.
- R6: While an entry's lock bit is set, writes to that entry's address register are ignored.
- R7: Writes to the address register of entry i are also ignored while entry i+1 is locked with mode top-of-range.
- R8: An address register stores write data bits [ADDR_W-1:0], with ADDR_W=32 for XLEN=32 and 54 for XLEN=64. Read data bits above ADDR_W are 0.
- R9: With GRAN>=1, an address whose entry is in mode off or top-of-range reads with bits GRAN-1:0 as 0. In mode power-of-two it reads with bits GRAN-2:0 as 1. In four-byte mode it reads unmodified. The stored bits survive and show again when the mode changes.
- R10: Read data reflects the state before the write edge. A write is visible on the read port and on the per-entry outputs in the cycle after the edge that takes it, and the per-entry outputs equal the values software reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we_i | input | 1 | Write strobe for the selected register |
| csr_addr_sel_i | input | 1 | 1 selects address registers, 0 selects packed permission registers |
| csr_idx_i | input | 6 | Register index |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Combinational read data of the selected register |
| entry_cfg_o | output | 8*N_ENTRIES | Permission byte of each entry, entry e at bits 8e+7:8e |
| entry_addr_o | output | ADDR_W*N_ENTRIES | Read-back address of each entry, entry e at bits ADDR_W*e+ADDR_W-1:ADDR_W*e |

## Verification
The assertions check four things on every cycle. A locked entry's byte and address never move, an address guarded by a locked top-of-range neighbour never moves, no more than one address register is written at a time, and an out-of-range address index reads 0. Only the bench's scenarios can show the rest: the byte lane and register each entry lands in under both data widths, the zero return from odd and unused indices, and the grain masking that hides stored bits and then shows them again when the mode changes. The bench checks these by reading every register after each write and comparing against an arithmetic model.

// File: rtl/pmpbank_pkg.sv
`timescale 1ns/1ps
// Shared field positions, mode codes and index arithmetic for the
// protection register bank. Assumes XLEN is 32 or 64.
package pmpbank_pkg;
    localparam int unsigned CFG_MODE_LO  = 3;
    localparam int unsigned CFG_BIT_LOCK = 7;
    localparam logic [7:0]  CFG_KEEP_MASK = 8'h9F;   // bits 6:5 never stored

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_TOR   = 2'b01,
        MODE_NA4   = 2'b10,
        MODE_NAPOT = 2'b11
    } mode_e;

    // Packed permission register that holds a given entry.
    function automatic int unsigned cfg_csr_of(input int unsigned entry, input int unsigned xlen);
        return (xlen == 64) ? ((entry >> 3) << 1) : (entry >> 2);
    endfunction

    // Byte lane of a given entry inside its permission register.
    function automatic int unsigned cfg_lane_of(input int unsigned entry, input int unsigned xlen);
        return entry % (xlen / 8);
    endfunction

    // Stored width of an address register.
    function automatic int unsigned addr_width_of(input int unsigned xlen);
        return (xlen == 64) ? 54 : 32;
    endfunction
endpackage

// File: rtl/pmp_entry.sv
`timescale 1ns/1ps
// One protection entry: permission byte and address register, both
// frozen by the entry's lock bit; the address is also frozen by a
// locked top-of-range neighbour (tor_guard_i). Address read-back applies
// the 2^(GRAN+2) byte grain. Assumes GRAN < ADDR_W.
module pmp_entry
    import pmpbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned GRAN   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [7:0]        cfg_wbyte_i,
    input  logic              addr_we_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    input  logic              tor_guard_i,
    output logic [7:0]        cfg_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [7:0]        cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic              locked;

    assign locked = cfg_q[CFG_BIT_LOCK];
    assign cfg_o  = cfg_q;

    // Permission byte: reset to off/unlocked, write only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we_i && !locked)
            cfg_q <= cfg_wbyte_i & CFG_KEEP_MASK;
    end

    // Address register: write only while neither this entry nor a TOR neighbour is locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (addr_we_i && !locked && !tor_guard_i)
            addr_q <= addr_wdata_i;
    end

    if (GRAN == 0) begin : g_fine
        // Four-byte grain: stored value reads back as is.
        assign addr_o = addr_q;
    end else begin : g_coarse
        localparam logic [ADDR_W-1:0] CLR_MASK = ADDR_W'((64'd1 << GRAN) - 64'd1);
        localparam logic [ADDR_W-1:0] SET_MASK = CLR_MASK >> 1;
        mode_e mode;
        assign mode = mode_e'(cfg_q[CFG_MODE_LO +: 2]);
        // Grain masking of the read-back value by current mode.
        always_comb begin
            unique case (mode)
                MODE_NAPOT: addr_o = addr_q | SET_MASK;
                MODE_NA4:   addr_o = addr_q;
                default:    addr_o = addr_q & ~CLR_MASK;
            endcase
        end
    end

    a_r5_locked_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(cfg_q));
    a_r6_locked_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(addr_q));
    a_r7_tor_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
        tor_guard_i |=> $stable(addr_q));
endmodule

// File: rtl/pmp_wr_decode.sv
`timescale 1ns/1ps
// Turns the register port's select/index/strobe into per-entry write
// enables. Indices that map to no entry produce no enable, so such
// writes are dropped. Assumes N_ENTRIES <= 2**IDX_W.
module pmp_wr_decode
    import pmpbank_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned N_ENTRIES = 16,
    parameter int unsigned IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic                 sel_addr_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [N_ENTRIES-1:0] cfg_we_o,
    output logic [N_ENTRIES-1:0] addr_we_o
);
    localparam int unsigned LANES = XLEN / 8;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
        localparam int unsigned CSR_IDX = cfg_csr_of(e, XLEN);
        // Enable for this entry's byte lane and its address register.
        assign cfg_we_o[e]  = we_i && !sel_addr_i && (idx_i == IDX_W'(CSR_IDX));
        assign addr_we_o[e] = we_i &&  sel_addr_i && (idx_i == IDX_W'(e));
    end

    a_r4_single_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(addr_we_o));
    a_r3_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cfg_we_o) <= LANES);
endmodule

// File: rtl/pmp_rd_mux.sv
`timescale 1ns/1ps
// Combinational read path: assembles a packed permission register from
// the entries' bytes, or returns one address register zero-extended.
// Unused lanes and unmapped indices read as zero.
module pmp_rd_mux
    import pmpbank_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned N_ENTRIES = 16,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned IDX_W     = 6
) (
    input  logic                          sel_addr_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [N_ENTRIES*8-1:0]        cfg_flat_i,
    input  logic [N_ENTRIES*ADDR_W-1:0]   addr_flat_i,
    output logic [XLEN-1:0]               rdata_o
);
    // Select and pack the addressed register.
    always_comb begin
        rdata_o = '0;
        if (sel_addr_i) begin
            for (int e = 0; e < N_ENTRIES; e++)
                if (idx_i == IDX_W'(e))
                    rdata_o = XLEN'(addr_flat_i[e*ADDR_W +: ADDR_W]);
        end else begin
            for (int e = 0; e < N_ENTRIES; e++)
                if (idx_i == IDX_W'(cfg_csr_of(e, XLEN)))
                    rdata_o[cfg_lane_of(e, XLEN)*8 +: 8] = cfg_flat_i[e*8 +: 8];
        end
    end
endmodule

// File: rtl/pmp_cfg_bank.sv
`timescale 1ns/1ps
// Protection register bank top: write decode, one pmp_entry per entry,
// top-of-range lock guard chain, and the read multiplexer. Assumes
// XLEN is 32 or 64, 1 <= N_ENTRIES <= 64, GRAN < 32.
module pmp_cfg_bank
    import pmpbank_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned N_ENTRIES = 16,
    parameter int unsigned GRAN      = 0,
    localparam int unsigned ADDR_W   = addr_width_of(XLEN),
    localparam int unsigned IDX_W    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        csr_we_i,
    input  logic                        csr_addr_sel_i,
    input  logic [IDX_W-1:0]            csr_idx_i,
    input  logic [XLEN-1:0]             csr_wdata_i,
    output logic [XLEN-1:0]             csr_rdata_o,
    output logic [N_ENTRIES*8-1:0]      entry_cfg_o,
    output logic [N_ENTRIES*ADDR_W-1:0] entry_addr_o
);
    logic [N_ENTRIES-1:0] cfg_we;
    logic [N_ENTRIES-1:0] addr_we;
    logic [N_ENTRIES-1:0] tor_guard;

    pmp_wr_decode #(.XLEN(XLEN), .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (csr_we_i),
        .sel_addr_i (csr_addr_sel_i),
        .idx_i      (csr_idx_i),
        .cfg_we_o   (cfg_we),
        .addr_we_o  (addr_we)
    );

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
        localparam int unsigned LANE = cfg_lane_of(e, XLEN);
        if (e + 1 < N_ENTRIES) begin : g_guard
            // Next entry locked in top-of-range mode freezes this address.
            assign tor_guard[e] = entry_cfg_o[(e+1)*8 + CFG_BIT_LOCK]
                && (entry_cfg_o[(e+1)*8 + CFG_MODE_LO +: 2] == MODE_TOR);
        end else begin : g_last
            assign tor_guard[e] = 1'b0;
        end

        pmp_entry #(.ADDR_W(ADDR_W), .GRAN(GRAN)) u_ent (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_we_i     (cfg_we[e]),
            .cfg_wbyte_i  (csr_wdata_i[LANE*8 +: 8]),
            .addr_we_i    (addr_we[e]),
            .addr_wdata_i (csr_wdata_i[ADDR_W-1:0]),
            .tor_guard_i  (tor_guard[e]),
            .cfg_o        (entry_cfg_o[e*8 +: 8]),
            .addr_o       (entry_addr_o[e*ADDR_W +: ADDR_W])
        );
    end

    pmp_rd_mux #(.XLEN(XLEN), .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd (
        .sel_addr_i  (csr_addr_sel_i),
        .idx_i       (csr_idx_i),
        .cfg_flat_i  (entry_cfg_o),
        .addr_flat_i (entry_addr_o),
        .rdata_o     (csr_rdata_o)
    );

    a_r4_dead_addr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr_sel_i && (32'(csr_idx_i) >= N_ENTRIES)) |-> (csr_rdata_o == '0));
endmodule

// File: tb/sim_pmp_cfg_bank.sv
`timescale 1ns/1ps
// Two configurations: u0 XLEN=32 GRAN=2, u1 XLEN=64 GRAN=0, 12 entries each.
module sim_pmp_cfg_bank;
    localparam int NE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        we0 = 0, sel0 = 0; logic [5:0] idx0 = 0; logic [31:0] wd0 = 0;
    logic        we1 = 0, sel1 = 0; logic [5:0] idx1 = 0; logic [63:0] wd1 = 0;
    logic [31:0] rd0; logic [63:0] rd1;
    logic [NE*8-1:0]  ec0, ec1;
    logic [NE*32-1:0] ea0;
    logic [NE*54-1:0] ea1;

    pmp_cfg_bank #(.XLEN(32), .N_ENTRIES(NE), .GRAN(2)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_we_i(we0), .csr_addr_sel_i(sel0), .csr_idx_i(idx0),
        .csr_wdata_i(wd0), .csr_rdata_o(rd0), .entry_cfg_o(ec0), .entry_addr_o(ea0));
    pmp_cfg_bank #(.XLEN(64), .N_ENTRIES(NE), .GRAN(0)) u1 (
        .clk(clk), .rst_n(rst_n), .csr_we_i(we1), .csr_addr_sel_i(sel1), .csr_idx_i(idx1),
        .csr_wdata_i(wd1), .csr_rdata_o(rd1), .entry_cfg_o(ec1), .entry_addr_o(ea1));

    logic [7:0]  mcfg  [2][NE];
    logic [63:0] maddr [2][NE];
    int nchk = 0, nbad = 0;
    logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

    function automatic logic [63:0] rnd();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed ^ (seed >> 29);
    endfunction

    // Expected read of an address register (R8, R9).
    function automatic logic [63:0] exp_addr(int d, int idx);
        logic [63:0] v;
        logic [1:0]  m;
        if (idx >= NE) return 64'h0;
        v = maddr[d][idx];
        m = mcfg[d][idx][4:3];
        if (d == 0) begin
            if (m == 2'b11) v = v | 64'h1;
            else if (m[1] == 1'b0) v = v & ~64'h3;
        end
        return v;
    endfunction

    // Expected read of a packed permission register (R3, R4).
    function automatic logic [63:0] exp_cfg(int d, int idx);
        logic [63:0] v = 64'h0;
        int lanes = (d == 0) ? 4 : 8;
        int base  = (d == 0) ? idx * 4 : (idx / 2) * 8;
        if (d == 1 && (idx % 2) == 1) return 64'h0;
        for (int l = 0; l < lanes; l++)
            if (base + l < NE) v[l*8 +: 8] = mcfg[d][base + l];
        return v;
    endfunction

    function automatic bit cfg_dead(int d, int idx);
        if (d == 1 && (idx % 2) == 1) return 1'b1;
        return ((d == 0) ? idx * 4 : (idx / 2) * 8) >= NE;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(int d, bit we, bit sel, int idx, logic [63:0] data);
        if (d == 0) begin we0 = we; sel0 = sel; idx0 = 6'(idx); wd0 = data[31:0]; end
        else        begin we1 = we; sel1 = sel; idx1 = 6'(idx); wd1 = data; end
    endtask

    function automatic logic [63:0] rd(int d);
        return (d == 0) ? {32'h0, rd0} : rd1;
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++)
            for (int e = 0; e < NE; e++) begin mcfg[d][e] = 8'h0; maddr[d][e] = 64'h0; end
    endtask

    // One register write; checks R10 (old value visible until the edge), then updates the model.
    task automatic wr(int d, bit sel, int idx, logic [63:0] data);
        bit guard;
        int lanes, base;
        @(negedge clk);
        drive(d, 1'b1, sel, idx, data);
        #1;
        chk("R10", "read before write edge", rd(d), sel ? exp_addr(d, idx) : exp_cfg(d, idx));
        @(negedge clk);
        drive(d, 1'b0, sel, idx, data);
        if (!sel) begin
            lanes = (d == 0) ? 4 : 8;
            base  = (d == 0) ? idx * 4 : (idx / 2) * 8;
            if (!(d == 1 && (idx % 2) == 1))
                for (int l = 0; l < lanes; l++)
                    if (base + l < NE && !mcfg[d][base + l][7])
                        mcfg[d][base + l] = data[l*8 +: 8] & 8'h9F;
        end else if (idx < NE) begin
            guard = (idx + 1 < NE) && mcfg[d][idx+1][7] && (mcfg[d][idx+1][4:3] == 2'b01);
            if (!mcfg[d][idx][7] && !guard)
                maddr[d][idx] = (d == 0) ? {32'h0, data[31:0]} : {10'h0, data[53:0]};
        end
    endtask

    // Read every index of both register kinds, then the per-entry outputs.
    task automatic sweep(int d, string ctag, string atag);
        logic [63:0] a;
        for (int i = 0; i < 64; i++) begin
            drive(d, 1'b0, 1'b0, i, 64'h0);
            #1;
            chk(cfg_dead(d, i) ? ((d == 1 && i % 2 == 1) ? "R3" : "R4") : ctag,
                $sformatf("dut%0d cfg[%0d]", d, i), rd(d), exp_cfg(d, i));
        end
        for (int i = 0; i < 64; i++) begin
            drive(d, 1'b0, 1'b1, i, 64'h0);
            #1;
            chk(i >= NE ? "R4" : atag, $sformatf("dut%0d addr[%0d]", d, i), rd(d), exp_addr(d, i));
        end
        for (int e = 0; e < NE; e++) begin
            a = (d == 0) ? {32'h0, ea0[e*32 +: 32]} : {10'h0, ea1[e*54 +: 54]};
            chk("R10", $sformatf("dut%0d out cfg %0d", d, e),
                (d == 0) ? {56'h0, ec0[e*8 +: 8]} : {56'h0, ec1[e*8 +: 8]}, {56'h0, mcfg[d][e]});
            chk("R10", $sformatf("dut%0d out addr %0d", d, e), a, exp_addr(d, e));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1: everything zero after reset
        for (int d = 0; d < 2; d++) sweep(d, "R1", "R1");

        // R2, R3, R8, R9: unlocked permission writes and address writes, full readback each time
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 16; i++) begin
                wr(d, 1'b0, i, rnd() & 64'h7F7F_7F7F_7F7F_7F7F);
                sweep(d, "R2/R3", "R8/R9");
            end
            for (int i = 0; i < 64; i++) begin
                wr(d, 1'b1, i, rnd());
                sweep(d, "R2/R3", "R8/R9");
            end
            // R9: mode changes reveal the stored low address bits again
            for (int i = 0; i < 4; i++) begin
                wr(d, 1'b0, i, rnd() & 64'h7F7F_7F7F_7F7F_7F7F);
                sweep(d, "R2/R3", "R9");
            end
        end

        // R5, R6, R7: entry1 locked NAPOT, entry3 locked TOR (guards entry2 address)
        wr(0, 1'b0, 0, 64'h8B05_9F01);
        wr(1, 1'b0, 0, 64'h1122_3344_8B05_9F01);
        for (int d = 0; d < 2; d++) begin
            sweep(d, "R5", "R6/R7");
            for (int i = 0; i < 4; i++) begin
                wr(d, 1'b1, i, rnd());
                sweep(d, "R5", "R6/R7");
            end
            for (int i = 0; i < 16; i++) begin
                wr(d, 1'b0, i, rnd());
                sweep(d, "R5", "R6/R7");
            end
            for (int i = 0; i < NE; i++) begin
                wr(d, 1'b1, i, rnd());
                sweep(d, "R5", "R6/R7");
            end
        end

        // R1: reset releases locks and clears state
        do_reset();
        for (int d = 0; d < 2; d++) sweep(d, "R1", "R1");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule